// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product. It spends one clock cycle on each multiplier bit, so it needs only one 32-bit adder and no array of partial products. A single 64-bit product register does most of the work. At start its upper half is cleared and its lower half takes the multiplier. On every step the register's least significant bit decides whether the captured multiplicand is added into the upper half. The whole register, together with the carry out of that add, then moves one place to the right. As the multiplier bits are used up, they are replaced by product bits coming in from the left.

The caller pulses `start` high for one cycle while the block is idle, with both operands present on the inputs. `busy` stays high while the 32 steps run. A one-cycle `done` pulse then marks the moment the 64-bit `product` is valid. The product stays on the output until the next accepted start. No overflow is flagged; the caller decides whether the upper 32 bits matter.

Top module: `seq_shift_mult`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active-low), `busy`, `done` and `product` are all 0 after that edge.
- R2: A `start` pulse (active high) sampled while `busy` is low makes `busy` high from the next cycle. `busy` stays high for exactly 32 consecutive cycles.
- R3: `done` is high for exactly one cycle. It rises in the first cycle after the 32 busy cycles, 33 cycles after the edge that accepted `start`, and `busy` is low in that cycle.
- R4: When `done` is high, `product` equals the unsigned 64-bit product of the two operands that were present when `start` was accepted.
- R5: The carry out of every 32-bit add is kept, so all-ones operands give 0xFFFFFFFE00000001.
- R6: A `start` that arrives while `busy` is high is ignored. The running multiply keeps its operands and its timing.
- R7: While `busy` is low and no `start` is seen, `product` holds its value.
- R8: Operands are captured only in the cycle that `start` is accepted. Changing them while busy has no effect on the result.
- R9: A zero in either operand gives a product of 0.
- R10: A `start` given in the same cycle that `done` is high is accepted, so multiplies can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiply; sampled only while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy | output | 1 | High while the 32 add-and-shift steps run |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 64 | 64-bit unsigned product, held until the next start |

## Verification
Timing is measured from the rising edge that accepts `start`. `busy` is high from the cycle after that edge and is due to fall 32 cycles later. `done` and the final `product` appear 33 cycles after the accepting edge. A behavioural reference in the bench advances on each rising edge using these counts. On every falling edge the bench compares `busy` and `done` against the reference, and compares `product` whenever the reference says the block is idle. Directed runs also count the falling edges from the start pulse to `done` and expect exactly 33, including runs that are disturbed by a start while busy, by operand changes while busy, and by a start given in the `done` cycle.

// File: rtl/seq_mult_pkg.sv
`timescale 1ns/1ps
// Shared types for the sequential shift-add multiplier.
// Assumes: only the controller state encoding is shared.
package seq_mult_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mult_state_t;
endpackage

// File: rtl/seq_mult_ctrl.sv
`timescale 1ns/1ps
// Controller: accepts a start while idle, then counts OP_W step cycles
// and raises a one-cycle done pulse after the last one.
// Assumes: start is ignored while running; synchronous active-low reset.
module seq_mult_ctrl
    import seq_mult_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic done
);
    localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OP_W - 1);

    mult_state_t      state_q;
    logic [CNT_W-1:0] step_cnt_q;
    logic             done_q;

    // Decode the accept and step strobes from the current state.
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
    end

    // Advance the state, the step counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                state_q    <= ST_RUN;
                step_cnt_q <= '0;
            end else if (step) begin
                step_cnt_q <= step_cnt_q + 1'b1;
                if (step_cnt_q == LAST_STEP) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/seq_mult_datapath.sv
`timescale 1ns/1ps
// Datapath: a multiplicand register, an OP_W-bit adder with carry out, and
// one 2*OP_W product register whose low half starts with the multiplier.
// Assumes: load and step are never high together.
module seq_mult_datapath #(
    parameter int OP_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [OP_W-1:0]      mcand_i,
    input  logic [OP_W-1:0]      mplier_i,
    output logic [2*OP_W-1:0]    product
);
    localparam int PROD_W = 2 * OP_W;

    logic [OP_W-1:0]   mcand_q;
    logic [PROD_W-1:0] prod_q;
    logic [OP_W-1:0]   addend;
    logic [OP_W:0]     upper_sum;

    // Conditional add of the multiplicand into the upper half, keeping the carry.
    always_comb begin
        addend    = prod_q[0] ? mcand_q : '0;
        upper_sum = {1'b0, prod_q[PROD_W-1:OP_W]} + {1'b0, addend};
    end

    // Capture operands on load; otherwise write back the sum and shift right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_i;
            prod_q  <= {{OP_W{1'b0}}, mplier_i};
        end else if (step) begin
            prod_q  <= {upper_sum, prod_q[OP_W-1:1]};
        end
    end

    assign product = prod_q;
endmodule

// File: rtl/seq_shift_mult.sv
`timescale 1ns/1ps
// Top: unsigned OP_W x OP_W sequential multiplier, one add-and-shift per cycle.
// Assumes: start is a level sampled each edge; accepted only while idle.
module seq_shift_mult #(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand_i,
    input  logic [OP_W-1:0]   mplier_i,
    output logic              busy,
    output logic              done,
    output logic [2*OP_W-1:0] product
);
    logic load;
    logic step;

    // Sequencing of accept, steps and completion.
    seq_mult_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    // Arithmetic and product storage.
    seq_mult_datapath #(.OP_W(OP_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .product  (product)
    );

    assign busy = step;
endmodule

// File: rtl/seq_shift_mult_chk.sv
`timescale 1ns/1ps
// Checker: observes the multiplier's ports and keeps its own record of the
// accepted operands and of the busy length to judge the protocol and result.
// Assumes: bound to every instance of seq_shift_mult.
module seq_shift_mult_chk #(
    parameter int OP_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   mcand_i,
    input logic [OP_W-1:0]   mplier_i,
    input logic              busy,
    input logic              done,
    input logic [2*OP_W-1:0] product
);
    localparam int CW = $clog2(OP_W + 1) + 1;

    logic [OP_W-1:0] cap_a;
    logic [OP_W-1:0] cap_b;
    logic [CW-1:0]   busy_len;

    // Record the operands of each accepted start and count busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            busy_len <= '0;
        end else if (start && !busy) begin
            cap_a    <= mcand_i;
            cap_b    <= mplier_i;
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + 1'b1;
        end
    end

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_busy_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_len == CW'(OP_W)));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_product_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ({{OP_W{1'b0}}, cap_a} * {{OP_W{1'b0}}, cap_b})));

    p_run_uninterrupted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_len != CW'(OP_W - 1)) |=> busy);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    p_zero_operand_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_a == '0 || cap_b == '0)) |-> (product == '0));
endmodule

bind seq_shift_mult seq_shift_mult_chk #(.OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy     (busy),
    .done     (done),
    .product  (product)
);

// File: tb/seq_shift_mult_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference advanced on each rising edge and compared on
// each falling edge, plus directed runs for latency and corner cases.
module seq_shift_mult_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        busy;
    logic        done;
    logic [63:0] product;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state.
    logic        m_busy;
    logic        m_done;
    logic [63:0] m_prod;
    logic [63:0] m_pend;
    int          m_cnt;

    seq_shift_mult uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mcand_i  (a),
        .mplier_i (b),
        .busy     (busy),
        .done     (done),
        .product  (product)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: updated from the requirements at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_cnt = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 32) begin
                    m_busy = 1'b0; m_done = 1'b1; m_prod = m_pend;
                end
            end else if (start) begin
                m_busy = 1'b1; m_cnt = 0;
                m_pend = 64'(a) * 64'(b);
            end
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && m_busy !== 1'bx) begin
            chk(busy === m_busy, "R2 busy", 64'(busy), 64'(m_busy));
            chk(done === m_done, "R3 done", 64'(done), 64'(m_done));
            if (!m_busy)
                chk(product === m_prod, "R7 product while idle", product, m_prod);
        end
    end

    // Run one multiply; optionally disturb it mid-run; check latency and result.
    // mode 0: plain, 1: start while busy (R6), 2: operand change while busy (R8)
    task automatic run(input logic [31:0] x, input logic [31:0] y, input int mode,
                       input bit now, input string req);
        int lat;
        logic [63:0] exp;
        exp = 64'(x) * 64'(y);
        if (!now) @(negedge clk);
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            if (lat == 10 && mode != 0) begin
                a = ~x; b = y ^ 32'h5A5A_0F0F;
                start = (mode == 1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == 33, {req, " latency"}, 64'(lat), 64'd33);
        chk(product === exp, {req, " result"}, product, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is applied
        chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done === 1'b0, "R1 done", 64'(done), 64'd0);
        chk(product === 64'd0, "R1 product", product, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run(32'd3, 32'd2, 0, 1'b0, "R4");
        run(32'hDEAD_BEEF, 32'h1234_5678, 0, 1'b0, "R4");
        run(32'h8000_0000, 32'd2, 0, 1'b0, "R4");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0, "R5");
        run(32'h0000_0000, 32'h1234_ABCD, 0, 1'b0, "R9");
        run(32'h89AB_CDEF, 32'h0000_0000, 0, 1'b0, "R9");
        run(32'h0F0F_1234, 32'h7777_0001, 1, 1'b0, "R6");
        run(32'h1357_9BDF, 32'hFEDC_BA98, 2, 1'b0, "R8");

        // R7: product holds while idle even as operand inputs move.
        begin
            logic [63:0] held;
            held = product;
            for (int i = 0; i < 6; i++) begin
                a = a + 32'd17; b = b ^ 32'hFFFF;
                @(negedge clk);
            end
            chk(product === held, "R7 hold", product, held);
        end

        // R10: start in the done cycle of the previous run.
        run(32'd5, 32'd7, 0, 1'b0, "R4");
        run(32'hABCD_0123, 32'h4567_89AB, 0, 1'b1, "R10");
        run(32'h0000_FFFF, 32'hFFFF_0000, 0, 1'b1, "R10");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule